// File: doc/BRIEF.md
# Cache Line Decay Controller

This block manages leakage for a group of cache lines. For every line it counts the clock cycles since that line was last touched. Once the idle count reaches the line's decay threshold, the line goes to sleep. In power-off mode the line is also invalidated, so its contents are lost. In drowsy mode the contents are kept and the valid flag stays set. An access that lands on a drowsy line raises a one-cycle wake stall, which tells the requester to hold off before it uses the data.

The threshold is either a single fixed value shared by all lines, or an adaptive per-line value. The adaptive value is twice the line's last measured gap between accesses, held between a programmable floor and ceiling. A line uses its adaptive threshold only after it has seen two accesses, because a gap cannot be measured before then. Until that point it falls back to the fixed value. The cache data array sits outside the block; the block drives only the per-line valid and sleep signals.

Top module: `cache_decay_ctrl`

## Requirements
- R1: The idle count of a line advances by one per cycle after an access. When a line's idle count is at least its threshold T and the line is awake, the line's sleep output rises at the next edge. In fixed mode T is `fixed_decay`, so sleep is seen high from the (T+1)-th edge after the access edge.
- R2: An access (`acc_valid` high, `acc_idx` = line number) clears that line's idle count and sleep output, and sets its valid output, all visible after the next edge. Other lines are not affected.
- R3: With `drowsy_en` = 0 at the decay edge, the line's valid output falls together with the rise of its sleep output.
- R4: With `drowsy_en` = 1 at the decay edge, the line's valid output is retained while sleep rises.
- R5: With `adapt_en` = 1, a line that has seen at least two accesses uses T = 2·G, where G is the idle count the line held at its latest access. If 2·G exceeds `max_decay`, T is `max_decay`; otherwise, if 2·G is below `min_decay`, T is `min_decay`. Lines with fewer than two accesses, and all lines when `adapt_en` = 0, use `fixed_decay`.
- R6: `wake_stall` is high for exactly the cycle after an access to a line whose sleep and valid outputs were both high at that access, and is low otherwise.
- R7: Idle counts saturate at 2^CNT_W−1 and do not wrap, so a measured gap after a long idle period is the saturated value.
- R8: After reset every line is invalid and awake, and `wake_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_idx | input | IDX_W | Index of the accessed line |
| adapt_en | input | 1 | 1: adaptive per-line threshold, 0: fixed threshold |
| drowsy_en | input | 1 | 1: decay keeps contents (drowsy), 0: decay invalidates |
| fixed_decay | input | CNT_W | Fixed decay threshold in cycles |
| min_decay | input | CNT_W+1 | Floor of the adaptive threshold |
| max_decay | input | CNT_W+1 | Ceiling of the adaptive threshold |
| line_valid | output | NUM_LINES | Per-line valid flag |
| line_sleep | output | NUM_LINES | Per-line sleep (low-leakage) request |
| wake_stall | output | 1 | One-cycle stall after an access hits a drowsy line |

## Verification
The bench builds the block with four lines and a 5-bit idle counter, so idle counts saturate at 31 within a short run. This lets the bench observe saturation directly: a gap longer than 31 cycles is measured as 31, and its doubled threshold of 62 lies above any reachable idle count. The short counter also keeps the fixed, adaptive, floor-clamped and ceiling-clamped thresholds, and both decay modes, within a few hundred cycles of stimulus.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  // Largest value an unsigned counter of width w can hold.
  function automatic int unsigned cnt_max(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/decay_thresh.sv
module decay_thresh #(
  parameter int CNT_W = 8
) (
  input  logic             adapt_en,
  input  logic             gap_known,
  input  logic [CNT_W-1:0] gap,
  input  logic [CNT_W-1:0] fixed_decay,
  input  logic [CNT_W:0]   min_decay,
  input  logic [CNT_W:0]   max_decay,
  output logic [CNT_W:0]   thresh
);
  logic [CNT_W:0] doubled;

  always_comb begin
    doubled = {gap, 1'b0};
    if (!adapt_en || !gap_known) thresh = {1'b0, fixed_decay};
    else if (doubled > max_decay) thresh = max_decay;
    else if (doubled < min_decay) thresh = min_decay;
    else thresh = doubled;
  end

  always_comb begin
    if (adapt_en && gap_known && (min_decay <= max_decay))
      a_range_r5: assert (thresh >= min_decay && thresh <= max_decay);
  end
endmodule

// File: rtl/decay_line.sv
module decay_line
  import cdc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             adapt_en,
  input  logic             drowsy_en,
  input  logic [CNT_W-1:0] fixed_decay,
  input  logic [CNT_W:0]   min_decay,
  input  logic [CNT_W:0]   max_decay,
  output logic             valid,
  output logic             sleep
);
  localparam logic [CNT_W-1:0] IDLE_MAX = CNT_W'(cnt_max(CNT_W));

  logic [CNT_W-1:0] idle_q, idle_d, gap_q, gap_d;
  logic [1:0]       seen_q, seen_d;
  logic             sleep_q, sleep_d, valid_q, valid_d;
  logic             decay;
  logic [CNT_W:0]   thresh;

  decay_thresh #(.CNT_W(CNT_W)) u_thresh (
    .adapt_en   (adapt_en),
    .gap_known  (seen_q == 2'd2),
    .gap        (gap_q),
    .fixed_decay(fixed_decay),
    .min_decay  (min_decay),
    .max_decay  (max_decay),
    .thresh     (thresh)
  );

  always_comb begin
    decay   = !hit && !sleep_q && ({1'b0, idle_q} >= thresh);
    idle_d  = idle_q;
    gap_d   = gap_q;
    seen_d  = seen_q;
    sleep_d = sleep_q;
    valid_d = valid_q;
    if (hit) begin
      idle_d  = '0;
      sleep_d = 1'b0;
      valid_d = 1'b1;
      if (seen_q != 2'd0) gap_d = idle_q;
      if (seen_q != 2'd2) seen_d = seen_q + 2'd1;
    end else begin
      if (idle_q != IDLE_MAX) idle_d = idle_q + 1'b1;
      if (decay) begin
        sleep_d = 1'b1;
        if (!drowsy_en) valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      gap_q   <= '0;
      seen_q  <= 2'd0;
      sleep_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      idle_q  <= idle_d;
      gap_q   <= gap_d;
      seen_q  <= seen_d;
      sleep_q <= sleep_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;
  assign sleep = sleep_q;

  p_hit_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!sleep && valid && idle_q == '0));
  p_off_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !drowsy_en && $rose(sleep_d)) |=> (sleep && !valid));
  p_drowsy_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && drowsy_en && !sleep && sleep_d && valid) |=> (sleep && valid));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && idle_q == IDLE_MAX) |=> (idle_q == IDLE_MAX));
  p_sleep_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !hit) |=> sleep);
endmodule

// File: rtl/cache_decay_ctrl.sv
module cache_decay_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic                 adapt_en,
  input  logic                 drowsy_en,
  input  logic [CNT_W-1:0]     fixed_decay,
  input  logic [CNT_W:0]       min_decay,
  input  logic [CNT_W:0]       max_decay,
  output logic [NUM_LINES-1:0] line_valid,
  output logic [NUM_LINES-1:0] line_sleep,
  output logic                 wake_stall
);
  logic [NUM_LINES-1:0] hit;
  logic                 wake_d, wake_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign hit[g] = acc_valid && (acc_idx == IDX_W'(g));
    decay_line #(.CNT_W(CNT_W)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit[g]),
      .adapt_en   (adapt_en),
      .drowsy_en  (drowsy_en),
      .fixed_decay(fixed_decay),
      .min_decay  (min_decay),
      .max_decay  (max_decay),
      .valid      (line_valid[g]),
      .sleep      (line_sleep[g])
    );
  end

  always_comb begin
    wake_d = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (hit[i] && line_sleep[i] && line_valid[i]) wake_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_stall = wake_q;

  p_wake_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stall |-> $past(acc_valid));
  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/cache_decay_ctrl_tb.sv
module cache_decay_ctrl_tb;
  localparam int N = 4;
  localparam int W = 5;
  localparam int SAT = 31;

  logic clk, rst_n, acc_valid, adapt_en, drowsy_en;
  logic [1:0] acc_idx;
  logic [W-1:0] fixed_decay;
  logic [W:0] min_decay, max_decay;
  logic [N-1:0] line_valid, line_sleep;
  logic wake_stall;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R8";

  int m_idle[N], m_gap[N], m_seen[N];
  bit m_sleep[N], m_valid[N], m_wake;

  cache_decay_ctrl #(.NUM_LINES(N), .CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .adapt_en(adapt_en), .drowsy_en(drowsy_en), .fixed_decay(fixed_decay),
    .min_decay(min_decay), .max_decay(max_decay),
    .line_valid(line_valid), .line_sleep(line_sleep), .wake_stall(wake_stall));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: behaviour taken from the requirements only.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wake = 0;
      for (int i = 0; i < N; i++) begin
        m_idle[i] = 0; m_gap[i] = 0; m_seen[i] = 0; m_sleep[i] = 0; m_valid[i] = 0;
      end
    end else begin
      m_wake = acc_valid && m_sleep[acc_idx] && m_valid[acc_idx];
      for (int i = 0; i < N; i++) begin
        int th;
        if (adapt_en && m_seen[i] >= 2) begin
          th = 2 * m_gap[i];
          if (th > int'(max_decay)) th = max_decay;
          else if (th < int'(min_decay)) th = min_decay;
        end else th = fixed_decay;
        if (acc_valid && acc_idx == i) begin
          if (m_seen[i] >= 1) m_gap[i] = m_idle[i];
          if (m_seen[i] < 2) m_seen[i]++;
          m_idle[i] = 0; m_sleep[i] = 0; m_valid[i] = 1;
        end else begin
          if (!m_sleep[i] && m_idle[i] >= th) begin
            m_sleep[i] = 1;
            if (!drowsy_en) m_valid[i] = 0;
          end
          if (m_idle[i] < SAT) m_idle[i]++;
        end
      end
    end
  end

  task automatic check(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] ev, es;
      for (int i = 0; i < N; i++) begin ev[i] = m_valid[i]; es[i] = m_sleep[i]; end
      check(req, "line_valid", line_valid, ev);
      check(req, "line_sleep", line_sleep, es);
      check(req, "wake_stall", wake_stall, m_wake);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(input int idx);
    @(negedge clk);
    acc_valid = 1'b1; acc_idx = idx[1:0];
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_idx = '0; adapt_en = 1'b0; drowsy_en = 1'b0;
    fixed_decay = 5'd6; min_decay = 6'd3; max_decay = 6'd40;
    idle(3);
    // R8: reset state
    check("R8", "reset valid", line_valid, 0);
    check("R8", "reset sleep", line_sleep, 0);
    check("R8", "reset wake", wake_stall, 0);
    rst_n = 1'b1;
    idle(2);
    // R2 and R1 and R3: fixed threshold, power-off decay
    req = "R2"; access(0);
    check("R2", "line0 valid after access", line_valid[0], 1);
    req = "R1"; idle(5);
    check("R1", "line0 awake before threshold", line_sleep[0], 0);
    idle(3);
    req = "R3";
    check("R1", "line0 asleep after threshold", line_sleep[0], 1);
    check("R3", "line0 invalid after power-off", line_valid[0], 0);
    // R4 and R6: drowsy decay, wake stall on access
    req = "R4"; drowsy_en = 1'b1; access(1); idle(10);
    check("R4", "line1 drowsy keeps valid", line_valid[1], 1);
    req = "R6"; access(1);
    check("R6", "wake after drowsy access", wake_stall, 1);
    idle(1);
    check("R6", "wake lasts one cycle", wake_stall, 0);
    // access to power-off line gives no stall
    access(0);
    check("R6", "no wake on invalid line", wake_stall, 0);
    // R5: adaptive threshold, floor clamp, mid value, ceiling
    req = "R5"; adapt_en = 1'b1; drowsy_en = 1'b0; fixed_decay = 5'd20;
    access(2); access(2);                       // gap 1 -> 2 -> floor 3
    idle(6);
    check("R5", "line2 floor-clamped decay", line_sleep[2], 1);
    access(2); idle(7); access(2);              // gap 8 -> 16
    idle(12);
    check("R5", "line2 awake under 2*gap", line_sleep[2], 0);
    idle(8);
    check("R5", "line2 asleep past 2*gap", line_sleep[2], 1);
    max_decay = 6'd10;
    access(2); idle(14); access(2);              // gap 15 -> 30 -> ceiling 10
    idle(12);
    check("R5", "line2 ceiling-clamped decay", line_sleep[2], 1);
    // R7: saturation then doubled gap beyond reach
    req = "R7"; max_decay = 6'd62; min_decay = 6'd3;
    access(3); idle(45); access(3);              // gap saturates at 31 -> 62
    idle(60);
    check("R7", "line3 never decays after saturated gap", line_sleep[3], 0);
    adapt_en = 1'b0; fixed_decay = 5'd4; idle(3);
    req = "R1";
    check("R1", "line3 decays under fixed mode", line_sleep[3], 1);
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule